// File: doc/BRIEF.md
# Auto-Reload Overflow Interval Timer

This block is a 32-bit interval timer driven from a simple register bus. Its counter runs upward and, on the count after it reaches all-ones, it overflows. At that point it either refills itself from a load register, which gives a repeating tick, or stops at zero, which gives a single timeout. Each overflow sets a sticky status flag. When the matching enable bit is set, that flag drives a level-sensitive interrupt line. Software clears the flag by writing a one to its bit.

To get a repeating interval, software writes the value all-ones minus N to both the counter and the load register. It then sets the run and auto-reload bits. The counter then overflows once every N+1 counts. An optional prescaler slows the count so that it advances once every 2^(ratio+1) clocks, which is never faster than every second clock. The bus has a one-cycle write strobe and a read strobe. Read data is combinational: it is valid in the same cycle as the read strobe and is zero when no read is in progress.

Top module: `ovf_interval_timer`

## Requirements
- R1: A read at word offset 0x00 returns the revision word {24'b0, major[3:0], minor[3:0]}, which is 0x00000021 by default. Writes to that offset change nothing.
- R2: Reads of any word offset other than 0x00, 0x06, 0x07, 0x09, 0x0A and 0x0B return zero. This includes the reserved interface-control slot at 0x10. Writes to those offsets have no effect.
- R3: The control word sits at offset 0x09. Its fields are: bit 0 run, bit 1 auto-reload, bits 4:2 prescale ratio, bit 5 prescale enable. The six bits read back as written. Writing 0 stops the count, and the counter then holds its value.
- R4: While run is 1 and prescale enable is 0, the counter at offset 0x0A rises by one on every clock edge. The first increment happens on the edge after the edge that set run.
- R5: While run is 1 and prescale enable is 1, the counter rises once every 2^(ratio+1) clocks. The first increment happens 2^(ratio+1) edges after the edge that set run.
- R6: With auto-reload set, the count after 0xFFFFFFFF loads the value held at offset 0x0B. Status bit 1 at offset 0x06 is set on that same edge.
- R7: With auto-reload clear, the count after 0xFFFFFFFF leaves the counter at 0, clears the run bit and sets status bit 1.
- R8: Writing a word with bit 1 set to offset 0x06 clears the overflow flag. Writing 0 leaves the flag unchanged.
- R9: The interrupt output equals status bit 1 AND bit 1 of the enable register at offset 0x07. It stays high until the flag or the enable is cleared.
- R10: A bus write to the counter takes priority over an increment in the same cycle. The written value is stored unchanged.
- R11: The load register at offset 0x0B reads back as written. Writing it does not change the counter.
- R12: Stopping the timer restarts the prescaler. After a restart, the first increment again comes a full 2^(ratio+1) edges after run is set.
- R13: An overflow in the same cycle as a clearing write to the status register leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_ofs | input | 5 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high, zero otherwise |
| irq | output | 1 | Overflow interrupt, active high level |

## Verification
The bench drives the counter up to the wrap point in both the repeating mode and the one-shot mode. A design that wraps one count early or late, or that forgets to drop the run bit in one-shot mode, returns a wrong counter or control read. It writes the counter in a cycle when an increment is also due, and clears the flag in the exact cycle an overflow sets it. An ordering fault shows up either as a value one too high or as a lost flag. It times the prescaled count at the exact edges where the 2 and 8 clock steps fall. It also restarts the timer after a stop in the middle of a prescale period. A prescaler that is not reset on stop then produces its first count too early.

// File: rtl/ovt_pkg.sv
package ovt_pkg;

    localparam int BUS_W   = 32;
    localparam int OFS_W   = 5;
    localparam int RATIO_W = 3;
    localparam int CTRL_W  = 6;
    localparam int OVF_BIT = 1;

    // Word offsets seen by software
    localparam logic [OFS_W-1:0] OFS_IDENT  = 5'h00;
    localparam logic [OFS_W-1:0] OFS_STATUS = 5'h06;
    localparam logic [OFS_W-1:0] OFS_INTEN  = 5'h07;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 5'h09;
    localparam logic [OFS_W-1:0] OFS_COUNT  = 5'h0A;
    localparam logic [OFS_W-1:0] OFS_RELOAD = 5'h0B;
    localparam logic [OFS_W-1:0] OFS_IFCFG  = 5'h10;

    // Control word, MSB first: bit5 prescale enable, bits4:2 ratio, bit1 auto-reload, bit0 run
    typedef struct packed {
        logic               pre_en;
        logic [RATIO_W-1:0] ratio;
        logic               autoreload;
        logic               run;
    } ctrl_t;

endpackage

// File: rtl/ovt_prescaler.sv
module ovt_prescaler #(
    parameter int RATIO_W = 3,
    parameter int PS_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               pre_en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);

    localparam int MAX_SHIFT = 1 << RATIO_W;

    typedef struct packed {
        logic [PS_W-1:0] pc;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [PS_W:0]   full_span;
    logic [PS_W-1:0] limit;
    logic            at_limit;

    initial begin
        if (PS_W < MAX_SHIFT) $error("prescaler counter too narrow for the ratio field");
    end

    always_comb begin
        full_span = (PS_W + 1)'(1) << (int'(ratio_i) + 1);
        limit     = full_span[PS_W-1:0] - PS_W'(1);
        at_limit  = (st_q.pc == limit);
        tick_o    = run_i && (!pre_en_i || at_limit);

        st_d = st_q;
        if (!run_i || !pre_en_i) begin
            st_d.pc = '0;
        end else if (at_limit) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = st_q.pc + PS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a prescaled count never lands on two adjacent clocks
    p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && pre_en_i) |=> (!tick_o || !pre_en_i));

    // R12: a stopped timer leaves the divider at its start
    p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (st_q.pc == '0));

endmodule

// File: rtl/ovt_counter.sv
module ovt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             autoreload_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             stop_req_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       ovf;

    always_comb begin
        ovf        = tick_i && !cnt_wr_i && (st_q.cnt == {CNT_W{1'b1}});
        stop_req_o = ovf && !autoreload_i;

        st_d = st_q;
        if (cnt_wr_i) begin
            st_d.cnt = wdata_i;
        end else if (ovf) begin
            st_d.cnt = autoreload_i ? load_i : '0;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        if (ovf) begin
            st_d.flag = 1'b1;
        end else if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;

    // R6: wrap in repeat mode refills from the load value and raises the flag
    p_wrap_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && autoreload_i) |=> (cnt_o == $past(load_i)) && flag_o);

    // R7: wrap in one-shot mode parks the counter at zero
    p_oneshot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !autoreload_i) |=> (cnt_o == '0) && flag_o);

    // R10: software value is taken over the increment
    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_i |=> (cnt_o == $past(wdata_i)));

    // R8: a clearing write with no overflow drops the flag
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !ovf) |=> !flag_o);

    // R13: overflow beats a simultaneous clear
    p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag_o);

    // R3: with no tick and no write, the count holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !cnt_wr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/ovf_interval_timer.sv
module ovf_interval_timer
    import ovt_pkg::*;
#(
    parameter int         DATA_W    = 32,
    parameter int         PS_W      = 8,
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [OFS_W-1:0]  bus_ofs,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int ID_PAD = DATA_W - 8;
    localparam int BIT_PAD = DATA_W - 2;

    typedef struct packed {
        ctrl_t             ctrl;
        logic              ie;
        logic [DATA_W-1:0] load;
    } top_state_t;

    top_state_t        st_d, st_q;
    logic              wr_ctrl, wr_ie, wr_load, wr_cnt, flag_clr;
    logic              tick, flag, stop_req;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] rd_mux;

    initial begin
        if (DATA_W < 8) $error("data width must hold the revision word");
    end

    ovt_prescaler #(
        .RATIO_W (RATIO_W),
        .PS_W    (PS_W)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q.ctrl.run),
        .pre_en_i (st_q.ctrl.pre_en),
        .ratio_i  (st_q.ctrl.ratio),
        .tick_o   (tick)
    );

    ovt_counter #(
        .CNT_W (DATA_W)
    ) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .autoreload_i (st_q.ctrl.autoreload),
        .cnt_wr_i     (wr_cnt),
        .wdata_i      (bus_wdata),
        .load_i       (st_q.load),
        .flag_clr_i   (flag_clr),
        .cnt_o        (cnt),
        .flag_o       (flag),
        .stop_req_o   (stop_req)
    );

    always_comb begin
        wr_ctrl  = bus_wr && (bus_ofs == OFS_CTRL);
        wr_ie    = bus_wr && (bus_ofs == OFS_INTEN);
        wr_load  = bus_wr && (bus_ofs == OFS_RELOAD);
        wr_cnt   = bus_wr && (bus_ofs == OFS_COUNT);
        flag_clr = bus_wr && (bus_ofs == OFS_STATUS) && bus_wdata[OVF_BIT];

        st_d = st_q;
        if (stop_req) begin
            st_d.ctrl.run = 1'b0;
        end
        if (wr_ctrl) begin
            st_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
        if (wr_ie) begin
            st_d.ie = bus_wdata[OVF_BIT];
        end
        if (wr_load) begin
            st_d.load = bus_wdata;
        end

        case (bus_ofs)
            OFS_IDENT:  rd_mux = {{ID_PAD{1'b0}}, REV_MAJOR, REV_MINOR};
            OFS_STATUS: rd_mux = {{BIT_PAD{1'b0}}, flag, 1'b0};
            OFS_INTEN:  rd_mux = {{BIT_PAD{1'b0}}, st_q.ie, 1'b0};
            OFS_CTRL:   rd_mux = {{(DATA_W-CTRL_W){1'b0}}, st_q.ctrl};
            OFS_COUNT:  rd_mux = cnt;
            OFS_RELOAD: rd_mux = st_q.load;
            OFS_IFCFG:  rd_mux = '0;
            default:    rd_mux = '0;
        endcase
        bus_rdata = bus_rd ? rd_mux : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = flag && st_q.ie;

    // R7: a one-shot wrap drops run unless software rewrites control in that cycle
    p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !wr_ctrl) |=> !st_q.ctrl.run);

    // R9: the interrupt stays up while no bus write touches the block
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq);

    // R11: writing the load register leaves the counter alone
    p_load_indep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_load && !tick) |=> $stable(cnt));

endmodule

// File: tb/ovf_interval_timer_test.sv
module ovf_interval_timer_test;

    localparam logic [4:0] O_ID = 5'h00, O_ST = 5'h06, O_IE = 5'h07, O_CT = 5'h09,
                           O_CN = 5'h0A, O_LD = 5'h0B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_ofs = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    ovf_interval_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_ofs   (bus_ofs),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Monitor: pop the expected read result and compare mid-cycle
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [4:0] ofs, input logic [31:0] d);
        bus_wr = 1'b1; bus_ofs = ofs; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] ofs, input logic [31:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_ofs = ofs;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
        @(posedge clk); #1;
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // Reset state
        rd(O_ID, 32'h21, "R1 revision after reset");
        rd(O_CT, 32'h0, "R3 control after reset");
        rd(O_CN, 32'h0, "R4 counter after reset");
        rd(O_ST, 32'h0, "R8 status after reset");
        chk_irq(1'b0, "R9 reset");

        // R2 unmapped and reserved offsets, R1 write ignored
        rd(5'h01, 32'h0, "R2 offset 0x01");
        rd(5'h10, 32'h0, "R2 offset 0x10");
        wr(5'h1F, 32'hFFFF_FFFF);
        rd(5'h1F, 32'h0, "R2 offset 0x1F");
        wr(O_ID, 32'hFFFF_FFFF);
        rd(O_ID, 32'h21, "R1 write ignored");

        // R11 load register, independent of counter
        wr(O_CN, 32'hFFFF_FFF0);
        wr(O_LD, 32'hFFFF_FFF0);
        rd(O_LD, 32'hFFFF_FFF0, "R11 load readback");
        rd(O_CN, 32'hFFFF_FFF0, "R11 counter unchanged by load write");

        // R4 / R6: repeating mode, no prescale
        wr(O_CT, 32'h3);                                   // cycle c
        rd(O_CN, 32'hFFFF_FFF0, "R4 first cycle after start");   // c+1
        idle(3);                                           // c+2..c+4
        rd(O_CN, 32'hFFFF_FFF4, "R4 count per clock");     // c+5
        idle(10);                                          // c+6..c+15
        rd(O_CN, 32'hFFFF_FFFF, "R6 at all-ones");         // c+16
        rd(O_CN, 32'hFFFF_FFF0, "R6 reloaded");            // c+17
        rd(O_ST, 32'h2, "R6 flag set");                    // c+18
        chk_irq(1'b0, "R9 masked");                        // c+19 (count at end: F3)
        wr(O_CT, 32'h0);                                   // c+20, count becomes F4
        rd(O_CN, 32'hFFFF_FFF4, "R3 stopped");
        idle(4);
        rd(O_CN, 32'hFFFF_FFF4, "R3 holds while stopped");
        rd(O_CT, 32'h0, "R3 control cleared");

        // R8 write-one-to-clear
        wr(O_ST, 32'h0);
        rd(O_ST, 32'h2, "R8 zero write keeps flag");
        wr(O_ST, 32'h2);
        rd(O_ST, 32'h0, "R8 one write clears flag");

        // R7 / R9 one-shot with interrupt
        wr(O_IE, 32'h2);
        rd(O_IE, 32'h2, "R9 enable readback");
        wr(O_CN, 32'hFFFF_FFFE);
        wr(O_CT, 32'h1);                                   // w
        chk_irq(1'b0, "R9 before wrap");                   // w+1
        idle(2);                                           // w+2, w+3
        chk_irq(1'b1, "R9 after wrap");                    // w+4
        rd(O_CN, 32'h0, "R7 counter parked at zero");
        rd(O_CT, 32'h0, "R7 run bit cleared");
        rd(O_ST, 32'h2, "R7 flag set");
        idle(3);
        rd(O_CN, 32'h0, "R7 stays at zero");
        chk_irq(1'b1, "R9 held until cleared");
        wr(O_ST, 32'h2);
        chk_irq(1'b0, "R9 dropped after clear");

        // R10 counter write beats increment
        wr(O_CN, 32'h100);
        wr(O_CT, 32'h3);                                   // a
        wr(O_CN, 32'h500);                                 // a+1, tick active
        rd(O_CN, 32'h500, "R10 write wins");               // a+2
        wr(O_CT, 32'h0);                                   // a+3
        rd(O_CN, 32'h502, "R10 counting resumed from written value");

        // R5 prescale ratio 0 (divide by 2)
        wr(O_CN, 32'h0);
        wr(O_CT, 32'h21);                                  // p
        rd(O_CN, 32'h0, "R5 div2 start");                  // p+1
        idle(4);
        rd(O_CN, 32'h2, "R5 div2 rate");                   // p+6
        rd(O_CT, 32'h21, "R3 control readback");

        // R5 prescale ratio 2 (divide by 8)
        wr(O_CT, 32'h0);
        wr(O_CN, 32'h0);
        wr(O_CT, 32'h29);                                  // q
        rd(O_CN, 32'h0, "R5 div8 start");                  // q+1
        idle(6);
        rd(O_CN, 32'h0, "R5 div8 before step");            // q+8
        rd(O_CN, 32'h1, "R5 div8 step");                   // q+9
        rd(O_CT, 32'h29, "R3 control readback ratio");     // q+10

        // R12 stop mid-period then restart
        wr(O_CT, 32'h0);
        wr(O_CN, 32'h10);
        wr(O_CT, 32'h29);                                  // r
        idle(7);                                           // r+1..r+7
        rd(O_CN, 32'h10, "R12 no early count after restart");  // r+8
        rd(O_CN, 32'h11, "R12 first count after restart");     // r+9
        wr(O_CT, 32'h0);

        // R13 overflow and clear in the same cycle
        wr(O_CN, 32'hFFFF_FFFE);
        wr(O_CT, 32'h3);                                   // w
        idle(1);                                           // w+1
        wr(O_ST, 32'h2);                                   // w+2: overflow edge
        wr(O_CT, 32'h0);
        rd(O_ST, 32'h2, "R13 set wins over clear");
        rd(O_CN, 32'hFFFF_FFF1, "R6 reload then one count");
        chk_irq(1'b1, "R13 irq up");
        wr(O_ST, 32'h2);
        chk_irq(1'b0, "R8 cleared");

        idle(2);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
        end
        done = 1'b1;
        report();
    end

endmodule